// File: doc/BRIEF.md
# Multi-Master I2C Single-Byte Controller

This block is an I2C master meant for a bus that other masters share. It keeps watching the two open-drain lines. When it sees a START made by any master it marks the bus busy, and a later STOP marks the bus free again. A command pulse latches a 7-bit target address, a direction bit and one write byte. The block holds the command until the bus is free. It then issues a START, sends the address byte, and either sends the write byte or receives one read byte. It closes the transfer with a STOP.

The block never drives a line high. It only enables a pull-low on SCL or SDA, and it reads both lines back through a synchroniser. Each SCL high phase is timed only after the line is actually seen high, so a slave can stretch the clock. If the block sees SDA low at a point where it has released SDA to send a 1, it has lost arbitration to another master. It lets go of both lines at once and reports the loss. At the end of every attempt it pulses a done flag. The nack and arbitration-lost flags and the read byte then stay valid until the next command is accepted.

Top module: `i2c_shared_master`

## Requirements
- R1: `bus_busy_o` goes high after a START on the lines (SDA falls while SCL is high), whichever master made it. It goes low after a STOP (SDA rises while SCL is high).
- R2: While `bus_busy_o` is high, a pending command drives neither line. The transfer starts only after the bus has become free.
- R3: The first byte after START is the 7-bit address followed by the direction bit (0 = write, 1 = read). It is sent most significant bit first.
- R4: On a write, the data byte follows the address, MSB first. The acknowledge is sampled on the ninth SCL pulse, and a high there (no acknowledge) sets `nack_o`.
- R5: A missing acknowledge on the address byte sets `nack_o` and skips the data byte. The transfer ends with a STOP.
- R6: On a read, eight bits are shifted in MSB first and presented on `rdata_o`. The block keeps SDA released during the ninth pulse (a NACK) and then sends a STOP.
- R7: Apart from exactly one START and one STOP, SDA changes only while SCL is low. The two output enables never change in the same clock cycle.
- R8: Every SCL high phase lasts at least `HALF_CYC` clocks, counted from when SCL is seen high. A slave holding SCL low therefore lengthens the low phase without shortening the high phase.
- R9: If SDA is seen low while the block sends a released 1, it releases both lines, pulses `done_o` with `arb_lost_o` set, and leaves the bus to the other master.
- R10: After reset both output enables are off and `busy_o`, `done_o` and `bus_busy_o` are low. `done_o` is a one-cycle pulse per transfer. When idle, no line is driven.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Command pulse, taken only when idle |
| addr_i | input | 7 | Target address |
| rnw_i | input | 1 | Direction: 0 write, 1 read |
| wdata_i | input | 8 | Byte to write |
| rdata_o | output | 8 | Byte read by the last read transfer |
| busy_o | output | 1 | Command pending or in progress |
| done_o | output | 1 | One-cycle end-of-transfer pulse |
| nack_o | output | 1 | Address or write byte not acknowledged |
| arb_lost_o | output | 1 | Transfer abandoned after losing arbitration |
| bus_busy_o | output | 1 | Bus held by some master (START seen, no STOP yet) |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe_o | output | 1 | Pull SCL low |
| sda_oe_o | output | 1 | Pull SDA low |

## Verification
The bench builds the block with `HALF_CYC` = 8 and the default two-stage synchroniser. A full byte then takes about 170 clocks, so dozens of random reads and writes fit easily in one run. At this setting a slave stretch of 12 to 40 clocks is longer than a whole low phase. A controller that timed its high phase from its own release, and not from the line it reads back, would then show an SCL high phase shorter than `HALF_CYC`. A second master model on the same lines exercises the busy wait and a loss on the first address bit.

// File: rtl/i2c_shared_pkg.sv
`timescale 1ns/1ps
package i2c_shared_pkg;
  localparam int unsigned ADDR_W = 7;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_WAIT,
    ST_START,
    ST_LOW,
    ST_HIGH,
    ST_STOP_LOW,
    ST_STOP_HIGH,
    ST_STOP_FREE,
    ST_DONE
  } mst_state_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic              rnw;
    logic [BYTE_W-1:0] wdata;
  } mst_cmd_t;
endpackage

// File: rtl/i2c_line_sync.sv
`timescale 1ns/1ps
module i2c_line_sync #(
  parameter int unsigned LINES  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LINES-1:0] line_i,
  output logic [LINES-1:0] line_o
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] ff_q;
    // idle bus level is high; reset there so no false edge appears
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ff_q <= '1;
      else         ff_q <= {ff_q[STAGES-2:0], line_i[g]};
    end
    assign line_o[g] = ff_q[STAGES-1];
  end
endmodule

// File: rtl/i2c_bus_monitor.sv
`timescale 1ns/1ps
module i2c_bus_monitor (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_s_i,
  input  logic sda_s_i,
  output logic bus_busy_o
);
  logic sda_q;
  logic start_ev, stop_ev;

  assign start_ev = scl_s_i &  sda_q & ~sda_s_i;
  assign stop_ev  = scl_s_i & ~sda_q &  sda_s_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sda_q      <= 1'b1;
      bus_busy_o <= 1'b0;
    end else begin
      sda_q <= sda_s_i;
      if (start_ev)     bus_busy_o <= 1'b1;
      else if (stop_ev) bus_busy_o <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_mst_engine.sv
`timescale 1ns/1ps
module i2c_mst_engine
  import i2c_shared_pkg::*;
#(
  parameter int unsigned HALF_CYC = 250
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  mst_cmd_t          cmd_i,
  input  logic              scl_s_i,
  input  logic              sda_s_i,
  input  logic              bus_busy_i,
  output logic              scl_oe_o,
  output logic              sda_oe_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              nack_o,
  output logic              arb_lost_o,
  output logic [BYTE_W-1:0] rdata_o
);
  localparam int unsigned CW = $clog2(HALF_CYC);
  localparam logic [CW-1:0] CNT_TOP = CW'(HALF_CYC - 1);
  localparam logic [CW-1:0] CNT_SET = CW'(HALF_CYC / 2);  // SDA update point inside low phase
  localparam logic [3:0]    ACK_BIT = 4'(BYTE_W);

  mst_state_e        state_q;
  logic [CW-1:0]     cnt_q;
  mst_cmd_t          cmd_q;
  logic              byte_q;
  logic [3:0]        bit_q;
  logic [BYTE_W-1:0] sh_q, rx_q;
  logic              scl_oe_q, sda_oe_q, nack_q, arb_q;

  logic is_tx, ack_slot, drv_low, sends_one, cnt_done, rd_byte;

  assign rd_byte   = byte_q & cmd_q.rnw;
  assign is_tx     = ~rd_byte;
  assign ack_slot  = (bit_q == ACK_BIT);
  assign drv_low   = ~ack_slot & is_tx & ~sh_q[BYTE_W-1];
  assign sends_one = ack_slot ? rd_byte : (is_tx & sh_q[BYTE_W-1]);
  assign cnt_done  = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      cmd_q    <= '0;
      byte_q   <= 1'b0;
      bit_q    <= '0;
      sh_q     <= '0;
      rx_q     <= '0;
      scl_oe_q <= 1'b0;
      sda_oe_q <= 1'b0;
      nack_q   <= 1'b0;
      arb_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (cmd_valid_i) begin
            cmd_q   <= cmd_i;
            nack_q  <= 1'b0;
            arb_q   <= 1'b0;
            state_q <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (!bus_busy_i && scl_s_i && sda_s_i) begin
            sda_oe_q <= 1'b1;
            cnt_q    <= CNT_TOP;
            state_q  <= ST_START;
          end
        end
        ST_START: begin
          if (cnt_done) begin
            scl_oe_q <= 1'b1;
            byte_q   <= 1'b0;
            bit_q    <= '0;
            sh_q     <= {cmd_q.addr, cmd_q.rnw};
            cnt_q    <= CNT_TOP;
            state_q  <= ST_LOW;
          end else begin
            cnt_q <= cnt_q - CW'(1);
          end
        end
        ST_LOW: begin
          if (cnt_q == CNT_SET) sda_oe_q <= drv_low;
          if (cnt_done) begin
            scl_oe_q <= 1'b0;
            cnt_q    <= CNT_TOP;
            state_q  <= ST_HIGH;
          end else begin
            cnt_q <= cnt_q - CW'(1);
          end
        end
        ST_HIGH: begin
          if (!scl_s_i) begin
            cnt_q <= CNT_TOP;  // line still low: stretched or not yet risen
          end else if (sends_one && !sda_s_i) begin
            arb_q    <= 1'b1;
            scl_oe_q <= 1'b0;
            sda_oe_q <= 1'b0;
            state_q  <= ST_DONE;
          end else if (!cnt_done) begin
            cnt_q <= cnt_q - CW'(1);
          end else begin
            cnt_q    <= CNT_TOP;
            scl_oe_q <= 1'b1;
            if (!ack_slot) begin
              sh_q  <= sh_q << 1;
              if (rd_byte) rx_q <= {rx_q[BYTE_W-2:0], sda_s_i};
              bit_q   <= bit_q + 4'd1;
              state_q <= ST_LOW;
            end else if (!byte_q && !sda_s_i) begin
              byte_q  <= 1'b1;
              bit_q   <= '0;
              sh_q    <= cmd_q.wdata;
              state_q <= ST_LOW;
            end else begin
              if (!rd_byte && sda_s_i) nack_q <= 1'b1;
              state_q <= ST_STOP_LOW;
            end
          end
        end
        ST_STOP_LOW: begin
          if (cnt_q == CNT_SET) sda_oe_q <= 1'b1;
          if (cnt_done) begin
            scl_oe_q <= 1'b0;
            cnt_q    <= CNT_TOP;
            state_q  <= ST_STOP_HIGH;
          end else begin
            cnt_q <= cnt_q - CW'(1);
          end
        end
        ST_STOP_HIGH: begin
          if (!scl_s_i) begin
            cnt_q <= CNT_TOP;
          end else if (cnt_done) begin
            sda_oe_q <= 1'b0;
            cnt_q    <= CNT_TOP;
            state_q  <= ST_STOP_FREE;
          end else begin
            cnt_q <= cnt_q - CW'(1);
          end
        end
        ST_STOP_FREE: begin
          if (cnt_done) state_q <= ST_DONE;
          else          cnt_q   <= cnt_q - CW'(1);
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign scl_oe_o   = scl_oe_q;
  assign sda_oe_o   = sda_oe_q;
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = (state_q == ST_DONE);
  assign nack_o     = nack_q;
  assign arb_lost_o = arb_q;
  assign rdata_o    = rx_q;
endmodule

// File: rtl/i2c_shared_master.sv
`timescale 1ns/1ps
module i2c_shared_master
  import i2c_shared_pkg::*;
#(
  parameter int unsigned HALF_CYC    = 250,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rnw_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              nack_o,
  output logic              arb_lost_o,
  output logic              bus_busy_o,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe_o,
  output logic              sda_oe_o
);
  logic [1:0] line_s;
  logic       scl_s, sda_s;
  mst_cmd_t   cmd;

  assign cmd = '{addr: addr_i, rnw: rnw_i, wdata: wdata_i};

  i2c_line_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .line_i ({scl_i, sda_i}),
    .line_o (line_s)
  );
  assign scl_s = line_s[1];
  assign sda_s = line_s[0];

  i2c_bus_monitor u_mon (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_s_i    (scl_s),
    .sda_s_i    (sda_s),
    .bus_busy_o (bus_busy_o)
  );

  i2c_mst_engine #(.HALF_CYC(HALF_CYC)) u_eng (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_valid_i (start_i),
    .cmd_i       (cmd),
    .scl_s_i     (scl_s),
    .sda_s_i     (sda_s),
    .bus_busy_i  (bus_busy_o),
    .scl_oe_o    (scl_oe_o),
    .sda_oe_o    (sda_oe_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .nack_o      (nack_o),
    .arb_lost_o  (arb_lost_o),
    .rdata_o     (rdata_o)
  );
endmodule

// File: rtl/i2c_shared_master_chk.sv
`timescale 1ns/1ps
module i2c_shared_master_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_oe_o,
  input logic sda_oe_o,
  input logic busy_o,
  input logic bus_busy_o,
  input logic done_o,
  input logic arb_lost_o,
  input logic scl_s,
  input logic sda_s
);
  AST_START_SETS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_s && $past(sda_s) && !sda_s) |=> bus_busy_o); // R1
  AST_STOP_CLEARS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_s && !$past(sda_s) && sda_s) |=> !bus_busy_o); // R1
  AST_START_ON_FREE_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(sda_oe_o) && !scl_oe_o) |-> !$past(bus_busy_o)); // R2
  AST_OE_APART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!$stable(sda_oe_o) && !$stable(scl_oe_o))); // R7
  AST_ARB_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && arb_lost_o) |-> (!scl_oe_o && !sda_oe_o)); // R9
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R10
  AST_IDLE_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!scl_oe_o && !sda_oe_o)); // R10
endmodule

bind i2c_shared_master i2c_shared_master_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .scl_oe_o   (scl_oe_o),
  .sda_oe_o   (sda_oe_o),
  .busy_o     (busy_o),
  .bus_busy_o (bus_busy_o),
  .done_o     (done_o),
  .arb_lost_o (arb_lost_o),
  .scl_s      (scl_s),
  .sda_s      (sda_s)
);

// File: tb/i2c_shared_master_tb_top.sv
`timescale 1ns/1ps
module i2c_shared_master_tb_top;
  localparam int unsigned HALF = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk = ~clk;

  logic       start = 1'b0, rnw = 1'b0;
  logic [6:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       busy, done, nack, arb_lost, bus_busy, scl_oe, sda_oe;
  logic       slv_scl_low = 1'b0, slv_sda_low = 1'b0;
  logic       oth_scl_low = 1'b0, oth_sda_low = 1'b0;
  logic       scl, sda;

  assign scl = ~(scl_oe | slv_scl_low | oth_scl_low);
  assign sda = ~(sda_oe | slv_sda_low | oth_sda_low);

  i2c_shared_master #(.HALF_CYC(HALF)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start), .addr_i(addr), .rnw_i(rnw),
    .wdata_i(wdata), .rdata_o(rdata), .busy_o(busy), .done_o(done), .nack_o(nack),
    .arb_lost_o(arb_lost), .bus_busy_o(bus_busy), .scl_i(scl), .sda_i(sda),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe)
  );

  int n_chk = 0, n_bad = 0;
  logic [7:0] cap_b0, cap_b1;
  logic       cap_mack;
  int         hi_edges = 0;
  logic       mon_on = 1'b0;
  realtime    t_rise = 0.0, min_high = 1.0e9;
  logic       s_done, s_nack, s_arb;
  logic [7:0] s_rdata;

  // bus observers
  always @(sda) if (mon_on && scl === 1'b1) hi_edges++;
  always @(posedge scl) t_rise = $realtime;
  always @(negedge scl) if (mon_on && ($realtime - t_rise) < min_high) min_high = $realtime - t_rise;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit exp_nack(input bit r, input bit ack_a, input bit ack_d);
    return !ack_a || (!r && !ack_d);
  endfunction

  task automatic issue(input logic [6:0] a, input logic r, input logic [7:0] w);
    @(negedge clk);
    addr = a; rnw = r; wdata = w; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    s_done = 1'b0;
    for (int n = 0; n < 20000; n++) begin
      @(negedge clk);
      if (done) begin
        s_done = 1'b1; s_nack = nack; s_arb = arb_lost; s_rdata = rdata;
        break;
      end
    end
  endtask

  task automatic wait_start();
    do @(negedge sda); while (scl !== 1'b1);
  endtask

  task automatic slave_serve(input bit ack_a, input bit ack_d, input logic [7:0] rd, input int stretch);
    logic [7:0] b0, b1;
    wait_start();
    for (int i = 7; i >= 0; i--) begin @(posedge scl); b0[i] = sda; end
    cap_b0 = b0;
    @(negedge scl); #2;
    slv_sda_low = ack_a;
    if (stretch > 0) begin
      slv_scl_low = 1'b1;
      repeat (stretch) @(negedge clk);
      slv_scl_low = 1'b0;
    end
    @(posedge scl); @(negedge scl); #2;
    slv_sda_low = 1'b0;
    if (!ack_a) return;
    if (b0[0]) begin
      for (int i = 7; i >= 0; i--) begin
        slv_sda_low = ~rd[i];
        @(posedge scl); @(negedge scl); #2;
      end
      slv_sda_low = 1'b0;
      @(posedge scl); cap_mack = sda;
      @(negedge scl);
    end else begin
      for (int i = 7; i >= 0; i--) begin @(posedge scl); b1[i] = sda; end
      cap_b1 = b1;
      @(negedge scl); #2;
      slv_sda_low = ack_d;
      @(posedge scl); @(negedge scl); #2;
      slv_sda_low = 1'b0;
    end
  endtask

  task automatic do_txn(input logic [6:0] a, input logic r, input logic [7:0] w,
                        input logic [7:0] rd, input bit ack_a, input bit ack_d, input int stretch);
    hi_edges = 0; min_high = 1.0e9; mon_on = 1'b1;
    cap_b0 = 'x; cap_b1 = 'x; cap_mack = 1'b0;
    fork
      begin issue(a, r, w); wait_done(); end
      slave_serve(ack_a, ack_d, rd, stretch);
    join
    mon_on = 1'b0;
    chk(s_done == 1'b1, "R10", "done pulse seen", s_done, 1);
    chk(cap_b0 == {a, r}, "R3", "address byte", cap_b0, {a, r});
    chk(s_nack == exp_nack(r, ack_a, ack_d), ack_a ? "R4" : "R5", "nack flag",
        s_nack, exp_nack(r, ack_a, ack_d));
    chk(s_arb == 1'b0, "R9", "no arbitration loss", s_arb, 0);
    if (ack_a && !r) chk(cap_b1 == w, "R4", "write byte", cap_b1, w);
    if (ack_a && r) begin
      chk(s_rdata == rd, "R6", "read byte", s_rdata, rd);
      chk(cap_mack == 1'b1, "R6", "master NACK on read", cap_mack, 1);
    end
    chk(hi_edges == 2, "R7", "SDA edges with SCL high", hi_edges, 2);
    chk(min_high >= real'(HALF) * 20.0, "R8", "min SCL high ns", longint'(min_high), HALF * 20);
    repeat (4 * HALF) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog run did not finish actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    int drove;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(!scl_oe && !sda_oe, "R10", "oe after reset", {scl_oe, sda_oe}, 0);
    chk(!busy && !done, "R10", "busy/done after reset", {busy, done}, 0);
    chk(!bus_busy, "R1", "bus free after reset", bus_busy, 0);

    do_txn(7'h2A, 1'b0, 8'hC3, 8'h00, 1'b1, 1'b1, 0);  // R4 plain write
    do_txn(7'h51, 1'b1, 8'h00, 8'hA5, 1'b1, 1'b1, 40); // R6 R8 read with long stretch
    do_txn(7'h13, 1'b0, 8'h7E, 8'h00, 1'b0, 1'b1, 0);  // R5 address nack
    do_txn(7'h6C, 1'b0, 8'h01, 8'h00, 1'b1, 1'b0, 20); // R4 data nack
    do_txn(7'h00, 1'b1, 8'h00, 8'hFF, 1'b1, 1'b1, 0);  // R6 all-ones read

    // R1 R2: another master holds the bus
    @(negedge clk); oth_sda_low = 1'b1;
    repeat (6) @(negedge clk);
    chk(bus_busy == 1'b1, "R1", "busy after foreign START", bus_busy, 1);
    cap_b0 = 'x;
    fork
      begin
        issue(7'h3B, 1'b0, 8'h99);
        drove = 0;
        for (int k = 0; k < 30 * HALF; k++) begin
          @(negedge clk);
          if (scl_oe || sda_oe) drove++;
        end
        chk(drove == 0, "R2", "cycles driven while bus busy", drove, 0);
        chk(busy == 1'b1, "R2", "command held pending", busy, 1);
        oth_sda_low = 1'b0;
        wait_done();
      end
      slave_serve(1'b1, 1'b1, 8'h00, 0);
    join
    chk(s_done && !s_nack && !s_arb, "R2", "transfer after bus freed", {s_done, s_nack, s_arb}, 3'b100);
    chk(cap_b0 == {7'h3B, 1'b0}, "R3", "address after wait", cap_b0, {7'h3B, 1'b0});
    repeat (4 * HALF) @(negedge clk);

    // R9 arbitration loss on first address bit (MSB of 0x55 is 1)
    fork
      begin issue(7'h55, 1'b0, 8'h12); wait_done(); end
      begin wait_start(); @(negedge scl); #2; oth_sda_low = 1'b1; end
    join
    chk(s_done && s_arb, "R9", "arbitration lost flagged", {s_done, s_arb}, 2'b11);
    chk(!s_nack, "R9", "no nack on loss", s_nack, 0);
    repeat (5) @(negedge clk);
    chk(!scl_oe && !sda_oe, "R9", "lines released after loss", {scl_oe, sda_oe}, 0);
    chk(scl == 1'b1, "R9", "SCL left high", scl, 1);
    chk(bus_busy == 1'b1, "R1", "bus still held by winner", bus_busy, 1);
    oth_sda_low = 1'b0;
    repeat (8) @(negedge clk);
    chk(bus_busy == 1'b0, "R1", "bus free after winner STOP", bus_busy, 0);
    repeat (2 * HALF) @(negedge clk);

    // random mix
    for (int t = 0; t < 30; t++) begin
      logic [6:0] a; logic r; logic [7:0] w, rd; bit aa, ad; int st;
      a  = 7'($urandom);
      r  = 1'($urandom);
      w  = 8'($urandom);
      rd = 8'($urandom);
      aa = ($urandom % 8) != 0;
      ad = ($urandom % 6) != 0;
      st = (($urandom % 3) == 0) ? 12 + int'($urandom % 29) : 0;
      do_txn(a, r, w, rd, aa, ad, st);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule